// File: doc/BRIEF.md
# Bus Parity Generator with System-Error NMI Forwarding

This block produces the parity bit for a shared 32-bit multiplexed address/data bus on an agent that acts as both initiator and target. For each bus phase it is given the AD value, the command/byte-enable value and three qualifiers that say whether this agent drives the phase: an address phase it issues as initiator, a write data phase it supplies as initiator, or a read data phase it returns as target. It registers even parity over all 36 bits and presents it, with an output enable, on the following clock. Phases driven by another agent produce no parity drive. Incoming parity is never checked.

The same block watches the active-low system-error line driven by other agents. When error reporting is enabled, an asserted error line raises a sticky non-maskable interrupt request. The request stays set until software pulses a clear input. The parity calculation is built either as one flat reduction or as a lane-folded tree, and a parameter selects which.

Top module: `bus_par_nmi`

## Requirements
- R1: Whenever `par_oe` is 1, the total count of ones in `par_out` together with the 32 AD bits and the 4 command/byte-enable bits of the phase it covers is even.
- R2: Every one of the 36 bits takes part in the parity whatever the byte-enable value is. Flipping any single bit of a driven phase flips `par_out`.
- R3: `par_out` and `par_oe` for a phase change only at the clock edge that samples that phase. Before that edge they still show the result of the previous phase.
- R4: A phase sampled with `addr_phase`=1 is driven. `par_oe` is 1 after that edge.
- R5: A phase sampled with `mst_wr_data`=1 is driven. `par_oe` is 1 after that edge.
- R6: A phase sampled with `tgt_rd_data`=1 is driven. `par_oe` is 1 after that edge.
- R7: A phase sampled with all three qualifiers at 0 gives `par_oe`=0 and `par_out`=0 after that edge. As a result, the enable drops one clock after the last driven phase.
- R8: If `serr_n`=0 and `nmi_en`=1 at a clock edge, `nmi` is 1 after that edge.
- R9: `nmi` stays 1 until an edge with `nmi_clr`=1 and no new error, and after that edge it is 0. A new error at the same edge as a clear keeps `nmi` at 1.
- R10: If `nmi_en`=0 at an edge, `nmi` is 0 after that edge, whatever the value of `serr_n`. Any pending request is discarded.
- R11: While `rst_n`=0, `par_out`, `par_oe` and `nmi` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ad_in | input | DATA_W (32) | AD value of the current phase |
| cbe_in | input | CMD_W (4) | Command/byte-enable value of the current phase |
| addr_phase | input | 1 | Current phase is an address phase issued by this agent |
| mst_wr_data | input | 1 | Current phase is write data supplied by this agent as initiator |
| tgt_rd_data | input | 1 | Current phase is read data returned by this agent as target |
| serr_n | input | 1 | System-error line from other agents, active low |
| nmi_en | input | 1 | Enables error-to-NMI forwarding |
| nmi_clr | input | 1 | Clears a pending NMI request |
| par_out | output | 1 | Even parity of the previous phase |
| par_oe | output | 1 | Drive enable for `par_out` |
| nmi | output | 1 | Sticky NMI request level |

## Verification
The bench walks a single one across all 36 bits under each of the eight qualifier combinations. It also sweeps every byte-enable value over fixed and pseudo-random AD words. A design that skipped byte lanes, or that dropped the command lines from the sum, would get these wrong. Each phase is checked before and after its sampling edge, so parity that appears combinationally, or two cycles late, is caught. A design that drove parity during master-read or target-write phases would also be caught, as would one that left the enable high after the last driven phase. On the interrupt side, the bench sets and clears the request at the same edge, leaves the line asserted while disabled, and drops the enable while a request is pending. A design that let the clear win, or that latched errors while forwarding was off, would fail these checks.

// File: rtl/bus_par_pkg.sv
package bus_par_pkg;

   // Qualifiers describing who owns the current bus phase
   typedef struct packed {
      logic addr;   // address phase issued by this agent
      logic mwr;    // write data supplied as initiator
      logic trd;    // read data returned as target
   } phase_q_t;

   localparam int PAR_FLAT = 0;
   localparam int PAR_LANE = 1;

   function automatic logic phase_driven(phase_q_t q);
      return q.addr | q.mwr | q.trd;
   endfunction

endpackage

// File: rtl/bus_par_tree.sv
module bus_par_tree #(
   parameter int DATA_W    = 32,
   parameter int CMD_W     = 4,
   parameter int PAR_STYLE = 1
) (
   input  logic [DATA_W-1:0] ad,
   input  logic [CMD_W-1:0]  cbe,
   output logic              par
);
   import bus_par_pkg::*;

   localparam int LANE_W = DATA_W / CMD_W;

   generate
      if (PAR_STYLE == PAR_FLAT) begin : g_flat
         assign par = ^{ad, cbe};
      end else begin : g_lane
         logic [CMD_W-1:0] lane_par;
         for (genvar i = 0; i < CMD_W; i++) begin : g_l
            assign lane_par[i] = (^ad[i*LANE_W +: LANE_W]) ^ cbe[i];
         end
         assign par = ^lane_par;
      end
   endgenerate

endmodule

// File: rtl/bus_par_drive.sv
module bus_par_drive (
   input  logic                  clk,
   input  logic                  rst_n,
   input  bus_par_pkg::phase_q_t ph,
   input  logic                  par_calc,
   output logic                  par_out,
   output logic                  par_oe
);
   import bus_par_pkg::*;

   logic drive;
   assign drive = phase_driven(ph);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         par_out <= 1'b0;
         par_oe  <= 1'b0;
      end else begin
         par_out <= drive & par_calc;
         par_oe  <= drive;
      end
   end

   assert_drive_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ph.addr |=> par_oe);
   assert_drive_mwr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ph.mwr |=> par_oe);
   assert_drive_trd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ph.trd |=> par_oe);
   assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ph.addr && !ph.mwr && !ph.trd) |=> (!par_oe && !par_out));

endmodule

// File: rtl/bus_serr_nmi.sv
module bus_serr_nmi (
   input  logic clk,
   input  logic rst_n,
   input  logic serr_n,
   input  logic nmi_en,
   input  logic nmi_clr,
   output logic nmi
);

   logic err_seen;
   assign err_seen = ~serr_n;

   always_ff @(posedge clk) begin
      if (!rst_n)
         nmi <= 1'b0;
      else if (!nmi_en)
         nmi <= 1'b0;
      else if (err_seen)
         nmi <= 1'b1;
      else if (nmi_clr)
         nmi <= 1'b0;
   end

   assert_nmi_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!serr_n && nmi_en) |=> nmi);
   assert_nmi_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi && nmi_en && !nmi_clr) |=> nmi);
   assert_nmi_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !nmi_en |=> !nmi);

endmodule

// File: rtl/bus_par_nmi.sv
module bus_par_nmi #(
   parameter int DATA_W    = 32,
   parameter int CMD_W     = 4,
   parameter int PAR_STYLE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ad_in,
   input  logic [CMD_W-1:0]  cbe_in,
   input  logic              addr_phase,
   input  logic              mst_wr_data,
   input  logic              tgt_rd_data,
   input  logic              serr_n,
   input  logic              nmi_en,
   input  logic              nmi_clr,
   output logic              par_out,
   output logic              par_oe,
   output logic              nmi
);
   import bus_par_pkg::*;

   localparam int LANE_W = DATA_W / CMD_W;

   generate
      if (CMD_W < 1 || DATA_W % CMD_W != 0) begin : g_bad_width
         $error("DATA_W must split evenly into CMD_W lanes");
      end
      if (LANE_W < 1) begin : g_bad_lane
         $error("each lane needs at least one data bit");
      end
      if (PAR_STYLE != PAR_FLAT && PAR_STYLE != PAR_LANE) begin : g_bad_style
         $error("PAR_STYLE must be 0 or 1");
      end
   endgenerate

   phase_q_t ph;
   logic     par_calc;

   assign ph.addr = addr_phase;
   assign ph.mwr  = mst_wr_data;
   assign ph.trd  = tgt_rd_data;

   bus_par_tree #(
      .DATA_W   (DATA_W),
      .CMD_W    (CMD_W),
      .PAR_STYLE(PAR_STYLE)
   ) u_tree (
      .ad (ad_in),
      .cbe(cbe_in),
      .par(par_calc)
   );

   bus_par_drive u_drive (
      .clk     (clk),
      .rst_n   (rst_n),
      .ph      (ph),
      .par_calc(par_calc),
      .par_out (par_out),
      .par_oe  (par_oe)
   );

   bus_serr_nmi u_nmi (
      .clk    (clk),
      .rst_n  (rst_n),
      .serr_n (serr_n),
      .nmi_en (nmi_en),
      .nmi_clr(nmi_clr),
      .nmi    (nmi)
   );

   // Even parity across the registered bit and the sampled phase
   assert_par_even_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_phase || mst_wr_data || tgt_rd_data)
         |=> ((par_out ^ (^$past(ad_in)) ^ (^$past(cbe_in))) == 1'b0));

endmodule

// File: tb/bus_par_nmi_test.sv
`timescale 1ns/1ps
module bus_par_nmi_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] ad_in;
   logic [3:0]  cbe_in;
   logic        addr_phase, mst_wr_data, tgt_rd_data;
   logic        serr_n, nmi_en, nmi_clr;
   logic        par_out, par_oe, nmi;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   logic prev_oe  = 1'b0;
   logic prev_par = 1'b0;
   logic [31:0] lfsr = 32'h1ACE_B00C;

   always #2.5 clk = ~clk;

   bus_par_nmi uut (
      .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_in(cbe_in),
      .addr_phase(addr_phase), .mst_wr_data(mst_wr_data), .tgt_rd_data(tgt_rd_data),
      .serr_n(serr_n), .nmi_en(nmi_en), .nmi_clr(nmi_clr),
      .par_out(par_out), .par_oe(par_oe), .nmi(nmi)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic even_bit(logic [31:0] a, logic [3:0] c);
      int ones = 0;
      for (int i = 0; i < 32; i++) ones += a[i];
      for (int i = 0; i < 4; i++) ones += c[i];
      return logic'(ones % 2);
   endfunction

   function automatic logic [31:0] next_rand(logic [31:0] x);
      logic [31:0] y = x;
      y ^= y << 13;
      y ^= y >> 17;
      y ^= y << 5;
      return y;
   endfunction

   // One phase: set at negedge, check old result held, check new result after edge
   task automatic phase(logic [31:0] a, logic [3:0] c, logic qa, logic qw, logic qr, string req);
      logic drv;
      logic exp_par;
      drv = qa | qw | qr;
      exp_par = drv ? even_bit(a, c) : 1'b0;
      @(negedge clk);
      ad_in = a; cbe_in = c;
      addr_phase = qa; mst_wr_data = qw; tgt_rd_data = qr;
      #1;
      chk("R3 oe before edge", {31'b0, par_oe}, {31'b0, prev_oe});
      chk("R3 par before edge", {31'b0, par_out}, {31'b0, prev_par});
      @(posedge clk);
      #1;
      chk(req, {31'b0, par_oe}, {31'b0, drv});
      chk(req, {31'b0, par_out}, {31'b0, exp_par});
      prev_oe = drv;
      prev_par = exp_par;
   endtask

   task automatic nmi_step(logic s_n, logic en, logic clr, logic exp, string req);
      @(negedge clk);
      serr_n = s_n; nmi_en = en; nmi_clr = clr;
      @(posedge clk);
      #1;
      chk(req, {31'b0, nmi}, {31'b0, exp});
   endtask

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      ad_in = 32'hFFFF_FFFF; cbe_in = 4'hF;
      addr_phase = 1'b1; mst_wr_data = 1'b1; tgt_rd_data = 1'b1;
      serr_n = 1'b0; nmi_en = 1'b1; nmi_clr = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R11 par_out in reset", {31'b0, par_out}, 32'd0);
      chk("R11 par_oe in reset", {31'b0, par_oe}, 32'd0);
      chk("R11 nmi in reset", {31'b0, nmi}, 32'd0);
      @(negedge clk);
      addr_phase = 1'b0; mst_wr_data = 1'b0; tgt_rd_data = 1'b0;
      serr_n = 1'b1; nmi_en = 1'b0;
      rst_n = 1'b1;

      // Walking one over all 36 bits under each qualifier combination (R1, R2, R4-R7)
      for (int q = 0; q < 8; q++) begin
         for (int b = 0; b < 36; b++) begin
            logic [35:0] v;
            string req;
            v = 36'd1 << b;
            if (q == 0) req = "R7 idle phase";
            else if (q[2]) req = "R4 address phase";
            else if (q[1]) req = "R5 master write data";
            else req = "R6 target read data";
            phase(v[35:4], v[3:0], q[2], q[1], q[0], req);
            if (q != 0) chk("R2 single bit flips par", {31'b0, par_out}, 32'd1);
         end
      end

      // Every byte-enable value over several AD words (R1, R2)
      for (int w = 0; w < 4; w++) begin
         logic [31:0] word;
         word = (w == 0) ? 32'h0 : (w == 1) ? 32'hFFFF_FFFF : lfsr;
         lfsr = next_rand(lfsr);
         for (int c = 0; c < 16; c++) begin
            phase(word, c[3:0], 1'b0, 1'b1, 1'b0, "R2 byte-enable sweep");
            chk("R1 even total", {31'b0, par_out ^ even_bit(word, c[3:0])}, 32'd0);
         end
      end

      // Pseudo-random mix, including drop of enable after last driven phase (R7)
      for (int k = 0; k < 64; k++) begin
         logic [31:0] a;
         a = lfsr;
         lfsr = next_rand(lfsr);
         phase(a, lfsr[3:0], lfsr[8] & lfsr[9], lfsr[10] & lfsr[11], lfsr[12] & lfsr[13],
               "R1 random phase");
         lfsr = next_rand(lfsr);
      end
      phase(32'hDEAD_BEEF, 4'h6, 1'b0, 1'b0, 1'b1, "R6 last driven phase");
      phase(32'hDEAD_BEEF, 4'h6, 1'b0, 1'b0, 1'b0, "R7 enable drops after last phase");

      // NMI forwarding
      nmi_step(1'b0, 1'b0, 1'b0, 1'b0, "R10 error ignored while disabled");
      nmi_step(1'b1, 1'b1, 1'b0, 1'b0, "R10 nothing latched while disabled");
      @(negedge clk);
      serr_n = 1'b0;
      #1;
      chk("R8 not before edge", {31'b0, nmi}, 32'd0);
      @(posedge clk);
      #1;
      chk("R8 set after edge", {31'b0, nmi}, 32'd1);
      for (int i = 0; i < 5; i++) nmi_step(1'b1, 1'b1, 1'b0, 1'b1, "R9 sticky hold");
      nmi_step(1'b1, 1'b1, 1'b1, 1'b0, "R9 clear pulse");
      nmi_step(1'b1, 1'b1, 1'b0, 1'b0, "R9 stays clear");
      nmi_step(1'b0, 1'b1, 1'b1, 1'b1, "R9 set wins over clear");
      nmi_step(1'b1, 1'b1, 1'b0, 1'b1, "R9 held after tie");
      nmi_step(1'b1, 1'b0, 1'b0, 1'b0, "R10 disable drops pending");
      nmi_step(1'b1, 1'b1, 1'b0, 1'b0, "R10 pending discarded");
      nmi_step(1'b0, 1'b1, 1'b0, 1'b1, "R8 set again");
      @(negedge clk);
      rst_n = 1'b0; serr_n = 1'b1; nmi_clr = 1'b0;
      @(posedge clk);
      #1;
      chk("R11 reset clears nmi", {31'b0, nmi}, 32'd0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule